// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Its guess depends on two things: low-order bits of the branch address and the outcomes of the branches that resolved just before it. A global history register holds the last M outcomes, where 1 marks taken and 0 marks not taken. The oldest outcome sits in the most significant bit and the newest enters at bit 0. The address bits select a row of counters, and the history value selects one N-bit saturating counter within that row. The most significant bit of that counter is the prediction. With the default sizes (4 address bits, M=2, N=2) the table holds 16 rows of 4 counters each.

Fetch sends a request carrying the branch address bits and receives the predicted direction together with the history value that was in effect for it. It keeps that history with the branch. When the branch resolves, the pipeline presents the address bits, the saved history and the real outcome on the update port. The block first trains the one counter picked by that address and that saved history. After that it shifts the real outcome into the global history.

The prediction channel is a combinational valid/ready pass-through. `pred_valid` follows `req_valid` and `req_ready` follows `pred_ready`. A request completes in the cycle in which both valid and ready are high. While the consumer holds `pred_ready` low, the request must stay on the port, and the answer does not change unless an update lands. The update port has no back-pressure: every cycle with `upd_valid` high is taken.

Top module: `corr_dir_predictor`

## Requirements
- R1: After reset the history is 0 and every counter holds weakly not-taken (value 1 for N=2), so every address is predicted not-taken and `pred_hist` reads 0.
- R2: `pred_taken` is the MSB of the counter at row `req_pc`, column = current history. `pred_hist` shows the current history.
- R3: On each `upd_valid` cycle the history becomes {history[M-2:0], `upd_taken`}. In cycles without an update the history holds.
- R4: An update changes only the counter at row `upd_pc`, column `upd_hist`. All other counters, including the other columns of the same row, keep their values.
- R5: A taken update increments the selected counter, stopping at 2^N-1. A not-taken update decrements it, stopping at 0.
- R6: A counter at strongly taken (3) still predicts taken after one not-taken update. It predicts not-taken only after a second one.
- R7: `pred_valid` equals `req_valid` and `req_ready` equals `pred_ready`. A prediction in the same cycle as an update reflects the state from before that update.
- R8: A branch whose outcome alternates T,N,T,N is predicted correctly on every occurrence after a short warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prediction request valid |
| req_ready | output | 1 | Request accepted (follows pred_ready) |
| req_pc | input | A (4) | Low-order branch address bits of the request |
| pred_valid | output | 1 | Prediction valid |
| pred_ready | input | 1 | Consumer can take the prediction |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | M (2) | History value used for this prediction |
| upd_valid | input | 1 | Resolved-branch update valid |
| upd_pc | input | A (4) | Low-order address bits of the resolved branch |
| upd_hist | input | M (2) | History saved with the branch at prediction time |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest state to reach is a specific counter at a known value while the live history also points at it. Every update moves the history, so the column just trained is usually not the one being read. The directed sequences train one counter by passing a fixed `upd_hist` value. They then steer the live history back to that column with two taken updates to an unrelated row, and only then read it. This exposes the saturation limits and the two-miss flip. A random phase draws addresses and outcomes from a seeded generator and checks every prediction against a bench model of the whole table.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  // Saturating step for counters up to 8 bits wide; the caller truncates.
  function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                          input logic [7:0] top,
                                          input logic       up);
    logic [7:0] r;
    if (up) r = (cur == top) ? cur : cur + 8'd1;
    else    r = (cur == 8'd0) ? cur : cur - 8'd1;
    return r;
  endfunction

endpackage

// File: rtl/cdp_ghist.sv
module cdp_ghist #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [M-1:0] hist_o
);

  logic [M-1:0] hist_q;

  generate
    if (M > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[M-2:0], bit_in};
      end

      AST_HIST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[M-1:1] == $past(hist_q[M-2:0])); // R3
    end else begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end
  endgenerate

  assign hist_o = hist_q;

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(bit_in)); // R3
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q)); // R3

endmodule

// File: rtl/cdp_sat_step.sv
module cdp_sat_step #(
  parameter int N = 2
) (
  input  logic [N-1:0] cur,
  input  logic         up,
  output logic [N-1:0] nxt
);
  import cdp_pkg::*;

  localparam logic [7:0] TOP = 8'((1 << N) - 1);

  logic [7:0] wide;

  always_comb begin
    wide = sat_step(8'(cur), TOP, up);
    nxt  = wide[N-1:0];
  end

endmodule

// File: rtl/cdp_table.sv
module cdp_table #(
  parameter int IDXW = 6,
  parameter int N    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_idx,
  output logic [N-1:0]    rd_ctr,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_up
);

  localparam int          DEPTH = 1 << IDXW;
  localparam logic [N-1:0] WEAK_NT = N'((1 << (N-1)) - 1);
  localparam logic [N-1:0] TOP     = N'((1 << N) - 1);

  logic [N-1:0] mem [DEPTH];
  logic [N-1:0] cur_ctr;
  logic [N-1:0] nxt_ctr;

  assign cur_ctr = mem[wr_idx];
  assign rd_ctr  = mem[rd_idx];

  cdp_sat_step #(.N(N)) u_step (
    .cur (cur_ctr),
    .up  (wr_up),
    .nxt (nxt_ctr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_ctr;
    end
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && cur_ctr == TOP) |=> mem[$past(wr_idx)] == TOP); // R5
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && cur_ctr == '0) |=> mem[$past(wr_idx)] == '0); // R5
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && cur_ctr != TOP) |=> mem[$past(wr_idx)] > $past(cur_ctr)); // R5
  AST_OTHER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx != wr_idx) |=> mem[$past(rd_idx)] == $past(rd_ctr)); // R4

endmodule

// File: rtl/corr_dir_predictor.sv
module corr_dir_predictor #(
  parameter int A = 4,
  parameter int M = 2,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [A-1:0] req_pc,
  output logic         pred_valid,
  input  logic         pred_ready,
  output logic         pred_taken,
  output logic [M-1:0] pred_hist,
  input  logic         upd_valid,
  input  logic [A-1:0] upd_pc,
  input  logic [M-1:0] upd_hist,
  input  logic         upd_taken
);

  localparam int IDXW = A + M;

  logic [M-1:0]    ghist;
  logic [N-1:0]    sel_ctr;
  logic [IDXW-1:0] rd_idx;
  logic [IDXW-1:0] wr_idx;

  assign rd_idx = {req_pc, ghist};
  assign wr_idx = {upd_pc, upd_hist};

  cdp_table #(.IDXW(IDXW), .N(N)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (rd_idx),
    .rd_ctr (sel_ctr),
    .wr_en  (upd_valid),
    .wr_idx (wr_idx),
    .wr_up  (upd_taken)
  );

  cdp_ghist #(.M(M)) u_ghist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist_o   (ghist)
  );

  assign pred_valid = req_valid;
  assign req_ready  = pred_ready;
  assign pred_taken = sel_ctr[N-1];
  assign pred_hist  = ghist;

  AST_HELD_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pred_ready && !upd_valid) |=>
      (!$stable(req_pc) || $stable(pred_taken))); // R7

endmodule

// File: tb/tb_corr_dir_predictor.sv
`timescale 1ns/1ps
module tb_corr_dir_predictor;

  localparam int A = 4;
  localparam int M = 2;
  localparam int N = 2;
  localparam real CLK_P = 4.0;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         req_valid = 0;
  logic         req_ready;
  logic [A-1:0] req_pc = '0;
  logic         pred_valid;
  logic         pred_ready = 0;
  logic         pred_taken;
  logic [M-1:0] pred_hist;
  logic         upd_valid = 0;
  logic [A-1:0] upd_pc = '0;
  logic [M-1:0] upd_hist = '0;
  logic         upd_taken = 0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [N-1:0] ref_ctr [64];
  logic [M-1:0] ref_hist;

  always #(CLK_P/2) clk = ~clk;

  corr_dir_predictor #(.A(A), .M(M), .N(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
    .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist),
    .upd_taken(upd_taken)
  );

  function automatic logic model_pred(input logic [A-1:0] pc);
    return ref_ctr[{pc, ref_hist}][N-1];
  endfunction

  function automatic logic [N-1:0] model_step(input logic [N-1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) ref_ctr[i] = 2'd1;
    ref_hist = '0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; upd_valid = 0; req_valid = 0; pred_ready = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  // Drive one cycle; optionally check the prediction against the model.
  task automatic step(input logic [A-1:0] rpc, input logic uv,
                      input logic [A-1:0] upc, input logic [M-1:0] uh,
                      input logic ut, input string tag, input bit chk);
    @(negedge clk);
    req_valid = 1; pred_ready = 1; req_pc = rpc;
    upd_valid = uv; upd_pc = upc; upd_hist = uh; upd_taken = ut;
    #1;
    if (chk) begin
      check(tag, int'(pred_taken), int'(model_pred(rpc)));
      check("R2 hist", int'(pred_hist), int'(ref_hist));
    end
    @(posedge clk);
    if (uv) begin
      ref_ctr[{upc, uh}] = model_step(ref_ctr[{upc, uh}], ut);
      ref_hist = {ref_hist[M-2:0], ut};
    end
    #0;
  endtask

  task automatic upd(input logic [A-1:0] pc, input logic [M-1:0] h, input logic t);
    step(pc, 1'b1, pc, h, t, "upd", 1'b0);
  endtask

  // Two taken updates to row 15 steer the live history to 11.
  task automatic hist_to_11();
    upd(4'd15, 2'b00, 1'b1);
    upd(4'd15, 2'b00, 1'b1);
  endtask

  task automatic peek(input logic [A-1:0] pc, input string tag, input logic exp_t);
    step(pc, 1'b0, '0, '0, 1'b0, tag, 1'b1);
    check(tag, int'(pred_taken), int'(exp_t));
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset();

    // R1: every row predicts not-taken with zero history
    for (int p = 0; p < 16; p++) begin
      step(4'(p), 1'b0, '0, '0, 1'b0, "R1 reset", 1'b1);
      check("R1 reset taken", int'(pred_taken), 0);
      check("R1 reset hist", int'(pred_hist), 0);
    end

    // R7: handshake pass-through
    @(negedge clk);
    req_valid = 0; pred_ready = 0; #1;
    check("R7 valid low", int'(pred_valid), 0);
    check("R7 ready low", int'(req_ready), 0);
    req_valid = 1; pred_ready = 1; #1;
    check("R7 valid high", int'(pred_valid), 1);
    check("R7 ready high", int'(req_ready), 1);

    // R3: history shifts newest into LSB
    upd(4'd0, 2'b00, 1'b1);
    step(4'd0, 1'b0, '0, '0, 1'b0, "R3", 1'b1);
    check("R3 hist after T", int'(pred_hist), 1);
    upd(4'd0, 2'b01, 1'b0);
    step(4'd0, 1'b0, '0, '0, 1'b0, "R3", 1'b1);
    check("R3 hist after T,N", int'(pred_hist), 2);
    step(4'd0, 1'b0, '0, '0, 1'b0, "R3", 1'b1);
    check("R3 hist holds", int'(pred_hist), 2);

    // R7: same-cycle update does not affect the prediction in that cycle
    do_reset();
    step(4'd6, 1'b1, 4'd6, 2'b00, 1'b1, "R7 same cycle", 1'b1);
    check("R7 same cycle old state", int'(pred_taken), 0);

    // R5/R6: strong taken survives one miss
    do_reset();
    upd(4'd3, 2'b11, 1'b1); upd(4'd3, 2'b11, 1'b1); upd(4'd3, 2'b11, 1'b1);
    upd(4'd3, 2'b11, 1'b0);
    hist_to_11();
    peek(4'd3, "R6 one miss still taken", 1'b1);
    upd(4'd3, 2'b11, 1'b0);
    hist_to_11();
    peek(4'd3, "R6 two misses flip", 1'b0);

    // R4: neighbouring row and columns untouched
    peek(4'd2, "R4 other row", 1'b0);
    upd(4'd3, 2'b01, 1'b1); upd(4'd3, 2'b01, 1'b1);
    hist_to_11();
    peek(4'd3, "R4 own column unaffected", 1'b0);

    // R5: bottom saturation
    upd(4'd7, 2'b11, 1'b0); upd(4'd7, 2'b11, 1'b0);
    upd(4'd7, 2'b11, 1'b1);
    hist_to_11();
    peek(4'd7, "R5 floor then one up", 1'b0);
    upd(4'd7, 2'b11, 1'b1);
    hist_to_11();
    peek(4'd7, "R5 floor then two up", 1'b1);

    // R8: alternating outcome on one branch
    do_reset();
    for (int i = 0; i < 24; i++) begin
      logic t;
      logic [M-1:0] h;
      t = (i % 2 == 0);
      h = ref_hist;
      if (i >= 8) begin
        step(4'd5, 1'b0, '0, '0, 1'b0, "R8", 1'b0);
        check("R8 alternating", int'(pred_taken), int'(t));
      end
      upd(4'd5, h, t);
    end

    // R2/R4/R5: random traffic against the model
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [A-1:0] rp, up;
      logic uv, ut;
      rp = 4'($urandom_range(15));
      up = 4'($urandom_range(3));
      uv = ($urandom_range(3) != 0);
      ut = ($urandom_range(3) != 0);
      step(rp, uv, up, ref_hist, ut, "R2 random", 1'b1);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule